// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD host from the system clock. A ten-bit control word sets the rate and the state of the clock. It holds a 7-bit divisor, a stop bit and two mode flags that are stored only.

The output comes straight from a flop. Each half period lasts the divisor plus one system cycles, so the card clock runs at the system clock divided by twice that amount. A new divisor is held back until the current low phase ends, so the output never produces a runt pulse. Setting the stop bit lets a high phase run to its end, then parks the output low.

Two strobes run in step with the output. Each is one system cycle wide and warns the command and data logic one cycle before a card-clock edge. This lets that logic launch or sample on the system clock without watching the card clock itself. There is no data stream, so every pin is a plain control or status pin.

Top module: `sdclk_gen`

## Requirements
- R1: With divisor d (control bits [6:0]), every high phase and every low phase of `sd_clk` lasts exactly d+1 system cycles.
- R2: Divisor 0 gives one-cycle halves, which is half the system clock. Divisor 127 gives 128-cycle halves.
- R3: A divisor written while the clock runs is first used for the high phase that follows the end of the current low phase. A phase already under way keeps the old length. If the write lands in a high phase, the low phase after it also keeps the old length.
- R4: Clearing the stop bit from the stopped state starts a low phase that uses the divisor written with it. The first rise of `sd_clk` comes d+2 system cycles after the clock edge that accepts the write.
- R5: Control bit 8 set stops the clock. If `sd_clk` is high, that high phase completes at its full length and the output then falls. If it is low, it stays low from then on. While stopped and low, `sd_clk` does not move and neither strobe is asserted.
- R6: `sd_rise_stb` is high in exactly the cycles just before a 0-to-1 change of `sd_clk`. `sd_fall_stb` is high in exactly the cycles just before a 1-to-0 change. The two are never high together.
- R7: The control word layout is divisor [6:0], SD-mode flag bit 7, stop bit 8 and high-speed flag bit 9. A write with `cfg_wr` replaces all ten bits, and `cfg_rdata` shows the new value from the next cycle on. The two mode flags do not change output timing.
- R8: After reset `cfg_rdata` reads 0x17F (divisor all ones, stop set, flags clear), `sd_clk` is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_wr | input | 1 | Write strobe for the control word, one cycle per write |
| cfg_wdata | input | 10 | Control word to store |
| cfg_rdata | output | 10 | Stored control word |
| sd_clk | output | 1 | Card clock, flop-driven |
| sd_rise_stb | output | 1 | High one cycle before each rise of sd_clk |
| sd_fall_stb | output | 1 | High one cycle before each fall of sd_clk |

## Verification
The properties assume that the control word changes only through `cfg_wr` and reset. This is why the stop bit as read back can stand in for the run request the divider sees. They also assume `rst_n` is held for at least one clock edge, so that the state register starts in its idle encoding. The stimulus makes every write a single-cycle pulse, driven away from the active edge. It times each divisor change or stop request against an observed card-clock edge, so that the write always lands in a known phase and the expected phase lengths are fixed.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Phase encoding: bit 1 is the card clock level itself, so the output
  // is a plain flop bit and never a decode of several bits.
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_HIGH = 2'b10
  } sdclk_phase_e;

  localparam int unsigned N_FLAGS = 3;  // SD mode, stop, high speed

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter  int DIV_W = 7,
  localparam int REG_W = DIV_W + N_FLAGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] word,
  output logic [DIV_W-1:0] div,
  output logic             stop
);

  localparam int STOP_BIT = DIV_W + 1;
  // Reset: flags clear, stop set, divisor all ones
  localparam logic [REG_W-1:0] RST_WORD =
    (REG_W'(1) << STOP_BIT) | REG_W'({DIV_W{1'b1}});

  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= RST_WORD;
    else if (wr)
      word_q <= wdata;
  end

  assign word = word_q;
  assign div  = word_q[DIV_W-1:0];
  assign stop = word_q[STOP_BIT];

endmodule

// File: rtl/sdclk_phase_ctr.sv
module sdclk_phase_ctr
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             sd_clk,
  output logic             rise_stb,
  output logic             fall_stb
);

  sdclk_phase_e     st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;   // divisor in force for the running phases
  logic             last;

  assign last = (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      act_q <= '1;
    end else begin
      case (st_q)
        PH_IDLE: begin
          cnt_q <= '0;
          act_q <= cfg_div;          // stopped: track the register freely
          if (run) st_q <= PH_LOW;
        end
        PH_LOW: begin
          if (!run) begin
            st_q  <= PH_IDLE;        // already low: park at once
            cnt_q <= '0;
          end else if (last) begin
            st_q  <= PH_HIGH;
            cnt_q <= '0;
            act_q <= cfg_div;        // only safe point to switch rate
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (last) begin
            st_q  <= run ? PH_LOW : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign sd_clk   = st_q[1];
  assign rise_stb = (st_q == PH_LOW) && run && last;
  assign fall_stb = (st_q == PH_HIGH) && last;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [DIV_W+N_FLAGS-1:0] cfg_wdata,
  output logic [DIV_W+N_FLAGS-1:0] cfg_rdata,
  output logic                     sd_clk,
  output logic                     sd_rise_stb,
  output logic                     sd_fall_stb
);

  logic [DIV_W-1:0] div;
  logic             stop;

  sdclk_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .word  (cfg_rdata),
    .div   (div),
    .stop  (stop)
  );

  sdclk_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!stop),
    .cfg_div  (div),
    .sd_clk   (sd_clk),
    .rise_stb (sd_rise_stb),
    .fall_stb (sd_fall_stb)
  );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DIV_W+N_FLAGS-1:0] cfg_rdata,
  input logic                     sd_clk,
  input logic                     sd_rise_stb,
  input logic                     sd_fall_stb
);

  localparam int STOP_BIT = DIV_W + 1;

  // R6: strobes are mutually exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_rise_stb && sd_fall_stb));

  // R6: a rise strobe is followed by a high output
  p_rise_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_rise_stb |=> sd_clk);

  // R6: a fall strobe is followed by a low output
  p_fall_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall_stb |=> !sd_clk);

  // R6: every rise was announced
  p_rise_warned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> $past(sd_rise_stb));

  // R5: stopped and low means it stays low
  p_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[STOP_BIT] && !sd_clk) |=> !sd_clk);

  // R5: no strobes while stopped and low
  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[STOP_BIT] && !sd_clk) |-> !(sd_rise_stb || sd_fall_stb));

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rdata   (cfg_rdata),
  .sd_clk      (sd_clk),
  .sd_rise_stb (sd_rise_stb),
  .sd_fall_stb (sd_fall_stb)
);

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;
  localparam int DIV_W = 7;
  localparam int REG_W = DIV_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [REG_W-1:0] cfg_wdata = '0;
  logic [REG_W-1:0] cfg_rdata;
  logic sd_clk, sd_rise_stb, sd_fall_stb;

  sdclk_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sd_clk(sd_clk),
    .sd_rise_stb(sd_rise_stb), .sd_fall_stb(sd_fall_stb)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // scoreboard: expected card-clock transitions
  bit    exp_lvl[$];
  int    exp_len[$];
  string exp_tag[$];
  int    ref_cyc = 0;
  bit    ref_ok = 1'b0;
  bit    mon_on = 1'b0;
  logic  prev_sd = 1'b0, prev_r = 1'b0, prev_f = 1'b0;
  logic  rose, fell;
  bit    lv;
  int    ln;
  string tg;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      rose = sd_clk && !prev_sd;
      fell = !sd_clk && prev_sd;
      if (rose || prev_r) check(prev_r == rose, "R6 rise strobe", prev_r, rose);
      if (fell || prev_f) check(prev_f == fell, "R6 fall strobe", prev_f, fell);
      if (sd_rise_stb && sd_fall_stb) check(1'b0, "R6 both strobes", 1, 0);
      if (rose || fell) begin
        if (ref_ok && exp_len.size() > 0) begin
          lv = exp_lvl.pop_front();
          ln = exp_len.pop_front();
          tg = exp_tag.pop_front();
          check(lv == sd_clk, {tg, " level"}, sd_clk, lv);
          check(ln == cyc - ref_cyc, {tg, " phase length"}, cyc - ref_cyc, ln);
        end
        ref_cyc = cyc;
        ref_ok  = 1'b1;
      end
    end
    prev_sd = sd_clk;
    prev_r  = sd_rise_stb;
    prev_f  = sd_fall_stb;
  end

  task automatic push(input bit l, input int n, input string t);
    exp_lvl.push_back(l);
    exp_len.push_back(n);
    exp_tag.push_back(t);
  endtask

  task automatic wr(input logic [REG_W-1:0] v, input bit set_ref);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    if (set_ref) begin
      ref_cyc = cyc;
      ref_ok  = 1'b1;
    end
  endtask

  task automatic readback(input logic [REG_W-1:0] v);
    @(negedge clk);
    check(cfg_rdata == v, "R7 readback", int'(cfg_rdata), int'(v));
  endtask

  task automatic drain();
    while (exp_len.size() != 0) @(negedge clk);
  endtask

  task automatic hold_low(input int n, input string t);
    repeat (n) begin
      @(negedge clk);
      check(!sd_clk && !sd_rise_stb && !sd_fall_stb, t,
            int'({sd_clk, sd_rise_stb, sd_fall_stb}), 0);
    end
  endtask

  // driver
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cfg_rdata == 10'h17F, "R8 reset word", int'(cfg_rdata), 'h17F);
    check(!sd_clk && !sd_rise_stb && !sd_fall_stb, "R8 reset outputs",
          int'({sd_clk, sd_rise_stb, sd_fall_stb}), 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    hold_low(8, "R8 stopped after reset");

    // divisor 2 from stopped state
    push(1'b1, 4, "R4");
    push(1'b0, 3, "R1");
    push(1'b1, 3, "R1");
    push(1'b0, 3, "R1");
    push(1'b1, 3, "R1");
    wr(10'h082, 1'b1);
    readback(10'h082);
    drain();

    // change to divisor 5 during a high phase
    push(1'b0, 3, "R3");
    push(1'b1, 3, "R3");
    push(1'b0, 6, "R3");
    push(1'b1, 6, "R3");
    push(1'b0, 6, "R1");
    push(1'b1, 6, "R1");
    wr(10'h085, 1'b0);
    drain();

    // stop during a high phase
    push(1'b0, 6, "R5");
    wr(10'h185, 1'b0);
    readback(10'h185);
    drain();
    hold_low(30, "R5 stopped after high phase");

    // fastest rate
    push(1'b1, 2, "R4");
    push(1'b0, 1, "R2");
    push(1'b1, 1, "R2");
    push(1'b0, 1, "R2");
    push(1'b1, 1, "R2");
    wr(10'h080, 1'b1);
    drain();
    wr(10'h100, 1'b0);
    repeat (4) @(negedge clk);
    hold_low(20, "R5 stopped at fastest rate");

    // slowest rate with high-speed flag set
    push(1'b1, 129, "R2");
    push(1'b0, 128, "R2");
    push(1'b1, 128, "R7");
    push(1'b0, 128, "R2");
    wr(10'h2FF, 1'b1);
    readback(10'h2FF);
    drain();

    // stop during a low phase
    wr(10'h3FF, 1'b0);
    readback(10'h3FF);
    hold_low(200, "R5 stopped during low phase");

    check(exp_len.size() == 0, "R1 scoreboard empty", exp_len.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", exp_len.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule